// File: doc/BRIEF.md
# Preemption Interrupt Generator

This block raises the non-maskable interrupt that forces a user process off the CPU of a small 8-bit multitasking machine. Its time base is a once-per-frame marker from the video timing, which arrives at roughly 50 Hz. Each marker that reaches the block unmasked decrements a countdown. When the countdown expires, the block drives an active-low interrupt line toward the CPU for a short, fixed pulse, then reloads the countdown.

Preemption exists only to take the CPU away from user processes that hold on to it. For that reason it is suppressed in two cases: while the process-ID register holds zero (the supervisor's own ID), and while a software mask bit is set. The mask bit lets the supervisor guard critical sections, much as an interrupt-disable flag guards ordinary interrupts. A frame marker that arrives while preemption is suppressed is dropped. It is not queued. A voluntary yield into the supervisor restarts the countdown, so a process that yields often enough never sees the interrupt.

A parameter selects how the frame marker is interpreted. The marker can be taken as a level whose rising edge counts as one tick, or as a ready-made one-cycle pulse. There is no data stream here. Every pin is a plain control or status signal.

Top module: `preempt_irq_gen`

## Requirements
- R1: After reset, `nmi_n` is high, the mask bit is set, the reload value is 1 and the countdown holds 1. The first unmasked tick after reset therefore fires once the mask bit is cleared.
- R2: With the default edge source, one tick is counted on each low-to-high transition of `frame_mark`. Holding `frame_mark` high for many cycles counts as a single tick.
- R3: While the mask bit is 1, ticks are discarded. No interrupt is produced, none is produced later when the mask bit is cleared, and the countdown keeps its value.
- R4: While `pid` equals zero, ticks are discarded in the same way, regardless of the mask bit.
- R5: With a reload value N, the interrupt fires on every Nth accepted tick. Firing reloads the countdown to N.
- R6: A `yield_strb` cycle reloads the countdown to the current reload value. A tick in the same cycle as a yield is not counted and cannot fire.
- R7: A `reload_wr` cycle stores `reload_data` as the new reload value, with 0 stored as 1. The countdown itself is not changed until the next fire or yield.
- R8: Each firing drives `nmi_n` low for exactly 2 clock cycles, starting on the clock edge that ends the cycle in which the tick was presented.
- R9: A firing that occurs while a pulse is still in progress neither extends nor restarts that pulse.
- R10: A `mask_wr` cycle loads `mask_data` into the mask bit, where 1 blocks and 0 allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_mark | input | 1 | End-of-visible-frame marker from the video timing |
| pid | input | PID_W | Current process-ID register value |
| yield_strb | input | 1 | One cycle per supervisor entry through a software-interrupt yield |
| mask_wr | input | 1 | Write strobe for the mask bit |
| mask_data | input | 1 | New mask bit value (1 = block) |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_data | input | CNT_W | New reload value, in ticks |
| nmi_n | output | 1 | Active-low preemption interrupt request |

## Verification
The assertions assume that `frame_mark`, `yield_strb` and the two write strobes are synchronous to `clk` and already free of glitches. They also assume that `pid` changes only between clock edges. The stimulus drives every input one time unit after a rising edge, and it leaves several idle cycles between frame markers, so each pulse ends before the next tick unless a test deliberately crowds them. The countdown checks assume the reload value is set and then followed by a yield before counting starts. Every stimulus vector follows that order, so the expected pulse count follows from the reload value and the tick count alone.

// File: rtl/preempt_pkg.sv
package preempt_pkg;

  // How the frame marker input is turned into ticks.
  typedef enum logic {
    TICK_PULSE = 1'b0,  // input is already a one-cycle pulse
    TICK_EDGE  = 1'b1   // rising edge of a level input
  } tick_mode_e;

  // Reload values of zero are meaningless; they are held as one.
  function automatic logic [15:0] clamp_reload(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction

endpackage

// File: rtl/preempt_tick_src.sv
module preempt_tick_src #(
  parameter preempt_pkg::tick_mode_e TICK_MODE = preempt_pkg::TICK_EDGE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_mark,
  output logic tick
);

  generate
    if (TICK_MODE == preempt_pkg::TICK_EDGE) begin : g_edge
      logic mark_prev_q;

      always_ff @(posedge clk) begin
        if (!rst_n) mark_prev_q <= 1'b1;
        else        mark_prev_q <= frame_mark;
      end

      assign tick = frame_mark & ~mark_prev_q;

      // R2
      one_tick_per_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pulse
      assign tick = frame_mark;
    end
  endgenerate

endmodule

// File: rtl/preempt_gate.sv
module preempt_gate #(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic             mask_data,
  input  logic [PID_W-1:0] pid,
  output logic             blocked
);

  localparam logic [PID_W-1:0] SUPER_PID = '0;

  logic mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign blocked = mask_q | (pid == SUPER_PID);

  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data)));

endmodule

// File: rtl/preempt_countdown.sv
module preempt_countdown #(
  parameter int CNT_W      = 8,
  parameter int RELOAD_DEF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_data,
  input  logic             tick,
  input  logic             blocked,
  input  logic             yield_strb,
  output logic             fire
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] DEF_LOAD = CNT_W'(preempt_pkg::clamp_reload(16'(RELOAD_DEF)));

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  always_ff @(posedge clk) begin
    if (!rst_n)         reload_q <= DEF_LOAD;
    else if (reload_wr) reload_q <= (reload_data == '0) ? ONE : reload_data;
  end

  assign accept = tick & ~blocked & ~yield_strb;
  assign fire   = accept & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= DEF_LOAD;
    else if (yield_strb) cnt_q <= reload_q;
    else if (fire)       cnt_q <= reload_q;
    else if (accept)     cnt_q <= cnt_q - ONE;
  end

  // R7
  reload_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q != '0);

  // R5
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  // R6
  yield_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_strb |=> (cnt_q == $past(reload_q)));

  // R3
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !yield_strb) |=> $stable(cnt_q));

endmodule

// File: rtl/preempt_pulse.sv
module preempt_pulse #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic nmi_n
);

  localparam int               SW   = $clog2(PULSE_LEN + 1);
  localparam logic [SW-1:0]    LOAD = SW'(PULSE_LEN);
  localparam logic [SW-1:0]    STEP = SW'(1);

  logic [SW-1:0] left_q;
  logic          busy;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             left_q <= '0;
    else if (busy)          left_q <= left_q - STEP;
    else if (fire)          left_q <= LOAD;
  end

  assign nmi_n = ~busy;

  // Checker: length of the current low run.
  logic [SW:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      low_run_q <= '0;
    else if (!nmi_n) low_run_q <= low_run_q + 1'b1;
    else             low_run_q <= '0;
  end

  // R8
  pulse_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= (SW+1)'(PULSE_LEN));

  // R8
  pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_n && low_run_q < (SW+1)'(PULSE_LEN - 1)) |=> !nmi_n);

  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |=> (left_q == $past(left_q) - STEP));

  // R8
  start_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && nmi_n) |=> !nmi_n);

endmodule

// File: rtl/preempt_irq_gen.sv
module preempt_irq_gen #(
  parameter int                       PID_W      = 8,
  parameter int                       CNT_W      = 8,
  parameter int                       RELOAD_DEF = 1,
  parameter int                       PULSE_LEN  = 2,
  parameter preempt_pkg::tick_mode_e  TICK_MODE  = preempt_pkg::TICK_EDGE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_mark,
  input  logic [PID_W-1:0] pid,
  input  logic             yield_strb,
  input  logic             mask_wr,
  input  logic             mask_data,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_data,
  output logic             nmi_n
);

  logic tick;
  logic blocked;
  logic fire;

  preempt_tick_src #(.TICK_MODE(TICK_MODE)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_mark (frame_mark),
    .tick       (tick)
  );

  preempt_gate #(.PID_W(PID_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .pid       (pid),
    .blocked   (blocked)
  );

  preempt_countdown #(.CNT_W(CNT_W), .RELOAD_DEF(RELOAD_DEF)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_wr   (reload_wr),
    .reload_data (reload_data),
    .tick        (tick),
    .blocked     (blocked),
    .yield_strb  (yield_strb),
    .fire        (fire)
  );

  preempt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .nmi_n (nmi_n)
  );

  // R4
  super_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pid == '0) |-> !fire);

  // R6
  yield_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_strb |-> !fire);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_n && !fire) |=> nmi_n);

endmodule

// File: tb/preempt_irq_gen_test.sv
module preempt_irq_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_mark = 1'b0;
  logic [7:0] pid = 8'd0;
  logic       yield_strb = 1'b0;
  logic       mask_wr = 1'b0;
  logic       mask_data = 1'b0;
  logic       reload_wr = 1'b0;
  logic [7:0] reload_data = 8'd0;
  logic       nmi_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  preempt_irq_gen uut (
    .clk (clk), .rst_n (rst_n), .frame_mark (frame_mark), .pid (pid),
    .yield_strb (yield_strb), .mask_wr (mask_wr), .mask_data (mask_data),
    .reload_wr (reload_wr), .reload_data (reload_data), .nmi_n (nmi_n)
  );

  // Pulse monitor, sampled away from the active edge.
  int pulses = 0;
  int low_w = 0;
  int last_w = 0;
  logic prev_n = 1'b1;
  always @(negedge clk) begin
    if (!nmi_n) low_w = low_w + 1;
    if (prev_n && !nmi_n) pulses = pulses + 1;
    if (!prev_n && nmi_n) begin last_w = low_w; low_w = 0; end
    prev_n = nmi_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int hold);
    @(posedge clk); #1 frame_mark = 1'b1;
    repeat (hold) @(posedge clk);
    #1 frame_mark = 1'b0;
    idle(6);
  endtask

  task automatic set_mask(input logic m);
    @(posedge clk); #1 mask_wr = 1'b1; mask_data = m;
    @(posedge clk); #1 mask_wr = 1'b0;
  endtask

  task automatic set_reload(input logic [7:0] r);
    @(posedge clk); #1 reload_wr = 1'b1; reload_data = r;
    @(posedge clk); #1 reload_wr = 1'b0;
  endtask

  task automatic do_yield();
    @(posedge clk); #1 yield_strb = 1'b1;
    @(posedge clk); #1 yield_strb = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] reload;
    logic       mask;
    logic [7:0] pid;
    logic [3:0] ticks;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{reload: 8'd1, mask: 1'b0, pid: 8'd5,   ticks: 4'd3},
    '{reload: 8'd2, mask: 1'b0, pid: 8'd5,   ticks: 4'd4},
    '{reload: 8'd3, mask: 1'b0, pid: 8'd7,   ticks: 4'd5},
    '{reload: 8'd4, mask: 1'b0, pid: 8'd1,   ticks: 4'd8},
    '{reload: 8'd2, mask: 1'b1, pid: 8'd5,   ticks: 4'd4},
    '{reload: 8'd2, mask: 1'b0, pid: 8'd0,   ticks: 4'd4},
    '{reload: 8'd5, mask: 1'b0, pid: 8'd255, ticks: 4'd4},
    '{reload: 8'd3, mask: 1'b0, pid: 8'd9,   ticks: 4'd6}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int base;
    int expv;
    idle(4);
    @(negedge clk);
    check(nmi_n === 1'b0 || nmi_n === 1'b1, "R1 nmi_n known in reset", int'(nmi_n), 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(nmi_n === 1'b1, "R1 idle after reset", int'(nmi_n), 1);

    // R1/R3: mask set at reset, tick discarded.
    pid = 8'd3;
    base = pulses;
    frame(1);
    check(pulses == base, "R1 mask set after reset", pulses - base, 0);
    // Unmask: no held tick appears; next tick fires (reload default 1).
    set_mask(1'b0);
    idle(4);
    check(pulses == base, "R3 masked tick not pending", pulses - base, 0);
    frame(1);
    check(pulses == base + 1, "R1 default reload is 1", pulses - base, 1);

    // R8: exact cycle placement and width.
    @(posedge clk); #1 frame_mark = 1'b1;
    @(negedge clk);
    check(nmi_n === 1'b1, "R8 high before edge", int'(nmi_n), 1);
    @(negedge clk);
    check(nmi_n === 1'b0, "R8 low first cycle", int'(nmi_n), 0);
    @(negedge clk);
    check(nmi_n === 1'b0, "R8 low second cycle", int'(nmi_n), 0);
    @(negedge clk);
    check(nmi_n === 1'b1, "R8 high third cycle", int'(nmi_n), 1);
    check(last_w == 2, "R8 width", last_w, 2);
    // R2: level held high counted only once.
    base = pulses;
    idle(10);
    #0 frame_mark = 1'b0;
    idle(4);
    check(pulses == base, "R2 held level single tick", pulses - base, 0);

    // Vector table.
    foreach (VECS[i]) begin
      set_reload(VECS[i].reload);
      set_mask(VECS[i].mask);
      pid = VECS[i].pid;
      do_yield();
      idle(4);
      base = pulses;
      for (int t = 0; t < int'(VECS[i].ticks); t++) frame(2);
      expv = (VECS[i].mask || VECS[i].pid == 8'd0) ? 0
             : int'(VECS[i].ticks) / int'(VECS[i].reload);
      check(pulses - base == expv, $sformatf("R5 vector %0d", i), pulses - base, expv);
    end

    // R4: pid zero blocks even with mask clear.
    set_mask(1'b0); set_reload(8'd1); pid = 8'd0; do_yield();
    base = pulses;
    frame(1); frame(1);
    check(pulses == base, "R4 supervisor pid blocks", pulses - base, 0);
    pid = 8'd4;
    frame(1);
    check(pulses == base + 1, "R4 user pid fires", pulses - base, 1);

    // R3: counter preserved across masked ticks.
    set_reload(8'd2); do_yield();
    base = pulses;
    frame(1);
    set_mask(1'b1); frame(1); frame(1); frame(1);
    set_mask(1'b0);
    check(pulses == base, "R3 masked ticks dropped", pulses - base, 0);
    frame(1);
    check(pulses == base + 1, "R3 count kept through mask", pulses - base, 1);

    // R6: yield restarts countdown.
    set_reload(8'd3); do_yield();
    base = pulses;
    frame(1); frame(1); do_yield(); frame(1); frame(1);
    check(pulses == base, "R6 yield restarts", pulses - base, 0);
    frame(1);
    check(pulses == base + 1, "R6 fires after restart", pulses - base, 1);
    // R6: tick coinciding with yield not counted.
    set_reload(8'd1); do_yield();
    base = pulses;
    @(posedge clk); #1 frame_mark = 1'b1; yield_strb = 1'b1;
    @(posedge clk); #1 frame_mark = 1'b0; yield_strb = 1'b0;
    idle(6);
    check(pulses == base, "R6 yield wins over tick", pulses - base, 0);

    // R7: writing zero acts as one.
    set_reload(8'd0); do_yield();
    base = pulses;
    frame(1); frame(1);
    check(pulses == base + 2, "R7 zero reload as one", pulses - base, 2);
    // R7: reload write alone leaves countdown.
    set_reload(8'd2); do_yield(); frame(1);
    set_reload(8'd5);
    base = pulses;
    frame(1);
    check(pulses == base + 1, "R7 write keeps countdown", pulses - base, 1);

    // R9: second fire during pulse ignored.
    set_reload(8'd1); do_yield();
    base = pulses;
    @(posedge clk); #1 frame_mark = 1'b1;
    @(posedge clk); #1 frame_mark = 1'b0;
    @(posedge clk); #1 frame_mark = 1'b1;
    @(posedge clk); #1 frame_mark = 1'b0;
    idle(6);
    check(pulses == base + 1, "R9 no retrigger count", pulses - base, 1);
    check(last_w == 2, "R9 no stretch", last_w, 2);

    // R10: mask write sets blocking again.
    set_mask(1'b1);
    base = pulses;
    frame(1);
    check(pulses == base, "R10 mask write blocks", pulses - base, 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule